// File: doc/BRIEF.md
# SD Command Issue and Status

This block is the command front end of an SD host controller, seen by software as a small register window. Software loads a 32-bit argument and then writes a 16-bit command word. If the start flag is set in that word, the block hands the 6-bit command index and the argument to a card-side request port over a valid/ready handshake. It then waits for the single-cycle reply, which carries a byte count, a 16-byte payload and an error bit.

The block checks the reply against the response type that the command word asked for and places the payload into four 32-bit response words. A bad reply sets a fail flag in the command word and a timeout bit in the status register. A command marked busy-wait that completes without error can raise a busy interrupt when this is enabled. Software clears status bits by writing ones to them. One interrupt line reflects the interrupt-class status bits.

Top module: `sdcf_front`

## Requirements
- R1: After reset the command word, argument, configuration, status and the four response words read as zero, `irq` is low and `req_valid` is low.
- R2: A write to the command register (offset 0x00) with bit 15 clear only stores the value, which reads back unchanged, and no request is made. The argument register (offset 0x04) stores and returns 32 bits.
- R3: A command write with bit 15 set, made while no command is outstanding, raises `req_valid` on the next cycle with `req_index` equal to bits 5:0 and `req_arg` equal to the argument. These hold until `req_ready`. Bit 15 reads as 1 until the reply arrives and as 0 afterwards. While a command is outstanding, writes to the command and argument registers are ignored.
- R4: A successful 4-byte reply puts payload bytes 0..3 (`rsp_payload[127:96]`, byte 0 most significant) into response word 0 (offset 0x10) and zeroes words 1..3 (offsets 0x14, 0x18, 0x1C).
- R5: A successful 16-byte reply fills word 0 from bytes 12..15 (`rsp_payload[31:0]`), word 1 from bytes 8..11, word 2 from bytes 4..7 and word 3 from bytes 0..3, each read big-endian.
- R6: When bit 10 (no-response) is clear, the reply is an error if `rsp_err` is set, if the length is 0, if the length is 4 and bit 9 (long response) is set, or if the length is neither 4 nor 16.
- R7: An error sets command bit 14 and status bit 6 (0x40), and leaves the response words unchanged.
- R8: When bit 10 is set, any reply length is accepted and the response words keep their values; `rsp_err` is still an error.
- R9: A command with bit 11 (busy-wait) set that completes without error sets status bit 10 (0x400) only if configuration bit 10 is set.
- R10: A write to the status register (offset 0x20) clears every status bit that is 1 in the written value and leaves the others.
- R11: `irq` is high exactly while any of status bits 10, 9 or 8 is set. This block itself sets only bit 10.
- R12: The configuration register (offset 0x38) stores 11 bits and reads back. Any other offset reads as zero and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| req_valid | output | 1 | Command request to the card side |
| req_ready | input | 1 | Card side accepts the request |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Reply present this cycle |
| rsp_len | input | LEN_W | Reply length in bytes |
| rsp_payload | input | 128 | Reply bytes, byte 0 in bits 127:120 |
| rsp_err | input | 1 | The request failed |
| irq | output | 1 | Interrupt request |

## Verification
Replies of 16 bytes with distinct bytes in every position show whether the word order is reversed and whether the bytes inside each word are kept big-endian. A 4-byte reply that follows a 16-byte reply shows whether the upper words are zeroed. Each error case is given on its own (long command with a short reply, an empty reply, an 8-byte reply, a failed request), so each term of the length check is tested separately. No-response commands given empty and full replies show that the response words are left alone. Busy-wait commands are run with the enable off, with the enable on, and with an error, which separates the enable gate from the success gate. A request held off by the card side tests the stall and that command writes are ignored during it.

// File: rtl/sdcf_pkg.sv
`timescale 1ns/1ps
package sdcf_pkg;
    localparam int WORD_W    = 32;
    localparam int RSP_WORDS = 4;
    localparam int RSP_W     = WORD_W * RSP_WORDS;
    localparam int CMD_W     = 16;
    localparam int IDX_W     = 6;
    localparam int STS_W     = 11;
    localparam int CFG_W     = 11;

    // register byte offsets
    localparam int OFF_CMD  = 'h00;
    localparam int OFF_ARG  = 'h04;
    localparam int OFF_RSP0 = 'h10;
    localparam int OFF_STS  = 'h20;
    localparam int OFF_CFG  = 'h38;

    // command word bits
    localparam int B_START = 15;
    localparam int B_FAIL  = 14;
    localparam int B_BUSY  = 11;
    localparam int B_NORSP = 10;
    localparam int B_LONG  = 9;

    // status and configuration bits
    localparam int S_BUSY_IRQ = 10;
    localparam int S_CMD_TO   = 6;
    localparam int C_BUSY_EN  = 10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [WORD_W-1:0] arg;
        logic [CFG_W-1:0]  cfg;
        logic [STS_W-1:0]  sts;
        logic [RSP_W-1:0]  rsp;
        phase_e            phase;
    } regs_t;
endpackage

// File: rtl/sdcf_reply_check.sv
`timescale 1ns/1ps
module sdcf_reply_check #(
    parameter int LEN_W  = 5,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4
) (
    input  logic [LEN_W-1:0]        len,
    input  logic                    req_err,
    input  logic                    no_rsp,
    input  logic                    long_rsp,
    input  logic [WORDS*WORD_W-1:0] payload,
    output logic                    fail,
    output logic [WORDS*WORD_W-1:0] words
);
    localparam int PAY_W = WORDS * WORD_W;
    localparam logic [LEN_W-1:0] SHORT_LEN = LEN_W'(WORD_W / 8);
    localparam logic [LEN_W-1:0] FULL_LEN  = LEN_W'(PAY_W / 8);

    logic is_short;
    logic bad_len;

    assign is_short = (len == SHORT_LEN);
    assign bad_len  = ((len != SHORT_LEN) && (len != FULL_LEN)) || (is_short && long_rsp);
    assign fail     = req_err || (!no_rsp && bad_len);

    // word 0 is the lowest slice; a short reply lands in word 0 from the top slice
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        if (w == 0) begin : g_low
            assign words[WORD_W-1:0] = is_short ? payload[PAY_W-1 -: WORD_W]
                                                : payload[WORD_W-1:0];
        end else begin : g_high
            assign words[w*WORD_W +: WORD_W] = is_short ? '0 : payload[w*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/sdcf_read_mux.sv
`timescale 1ns/1ps
module sdcf_read_mux import sdcf_pkg::*; #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [WORD_W-1:0] arg,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [STS_W-1:0]  sts,
    input  logic [RSP_W-1:0]  rsp,
    output logic [WORD_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_CMD)) rdata = WORD_W'(cmd);
        if (addr == ADDR_W'(OFF_ARG)) rdata = arg;
        if (addr == ADDR_W'(OFF_STS)) rdata = WORD_W'(sts);
        if (addr == ADDR_W'(OFF_CFG)) rdata = WORD_W'(cfg);
        for (int w = 0; w < RSP_WORDS; w++) begin
            if (addr == ADDR_W'(OFF_RSP0 + 4 * w)) rdata = rsp[w*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/sdcf_front.sv
`timescale 1ns/1ps
module sdcf_front import sdcf_pkg::*; #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [IDX_W-1:0]  req_index,
    output logic [WORD_W-1:0] req_arg,
    input  logic              rsp_valid,
    input  logic [LEN_W-1:0]  rsp_len,
    input  logic [RSP_W-1:0]  rsp_payload,
    input  logic              rsp_err,
    output logic              irq
);
    regs_t state_q, state_d;
    logic             rc_fail;
    logic [RSP_W-1:0] rc_words;
    logic             idle;

    sdcf_reply_check #(
        .LEN_W (LEN_W),
        .WORD_W(WORD_W),
        .WORDS (RSP_WORDS)
    ) u_reply_check (
        .len     (rsp_len),
        .req_err (rsp_err),
        .no_rsp  (state_q.cmd[B_NORSP]),
        .long_rsp(state_q.cmd[B_LONG]),
        .payload (rsp_payload),
        .fail    (rc_fail),
        .words   (rc_words)
    );

    sdcf_read_mux #(.ADDR_W(ADDR_W)) u_read_mux (
        .addr (bus_addr),
        .cmd  (state_q.cmd),
        .arg  (state_q.arg),
        .cfg  (state_q.cfg),
        .sts  (state_q.sts),
        .rsp  (state_q.rsp),
        .rdata(bus_rdata)
    );

    assign idle = (state_q.phase == ST_IDLE);

    always_comb begin
        state_d = state_q;

        if (bus_wr_en) begin
            if (bus_addr == ADDR_W'(OFF_CMD) && idle) begin
                state_d.cmd = bus_wdata[CMD_W-1:0];
                if (bus_wdata[B_START]) state_d.phase = ST_REQ;
            end
            if (bus_addr == ADDR_W'(OFF_ARG) && idle) state_d.arg = bus_wdata;
            if (bus_addr == ADDR_W'(OFF_STS)) state_d.sts = state_q.sts & ~bus_wdata[STS_W-1:0];
            if (bus_addr == ADDR_W'(OFF_CFG)) state_d.cfg = bus_wdata[CFG_W-1:0];
        end

        // completion comes after the clear so that a new event wins
        case (state_q.phase)
            ST_REQ: begin
                if (req_ready) state_d.phase = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    state_d.phase        = ST_IDLE;
                    state_d.cmd[B_START] = 1'b0;
                    if (rc_fail) begin
                        state_d.cmd[B_FAIL]   = 1'b1;
                        state_d.sts[S_CMD_TO] = 1'b1;
                    end else begin
                        if (!state_q.cmd[B_NORSP]) state_d.rsp = rc_words;
                        if (state_q.cmd[B_BUSY] && state_q.cfg[C_BUSY_EN])
                            state_d.sts[S_BUSY_IRQ] = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign req_valid = (state_q.phase == ST_REQ);
    assign req_index = state_q.cmd[IDX_W-1:0];
    assign req_arg   = state_q.arg;
    assign irq       = |state_q.sts[S_BUSY_IRQ:8];
endmodule

// File: rtl/sdcf_check.sv
`timescale 1ns/1ps
module sdcf_check import sdcf_pkg::*; #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic [IDX_W-1:0]  req_index,
    input logic [WORD_W-1:0] req_arg,
    input logic              rsp_valid,
    input phase_e            phase,
    input logic [CMD_W-1:0]  cmd_q,
    input logic [STS_W-1:0]  sts_q,
    input logic [RSP_W-1:0]  rsp_q,
    input logic              fail
);
    logic done;
    assign done = (phase == ST_WAIT) && rsp_valid;

    p_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(OFF_CMD) && bus_wdata[B_START] && phase == ST_IDLE)
        |=> req_valid);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_index) && $stable(req_arg)));

    p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !cmd_q[B_START]);

    p_fail_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |=> (cmd_q[B_FAIL] && sts_q[S_CMD_TO] && $stable(rsp_q)));

    p_keep_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_q[B_NORSP]) |=> $stable(rsp_q));

    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(OFF_STS) && bus_wdata[S_CMD_TO] && !done)
        |=> !sts_q[S_CMD_TO]);
endmodule

bind sdcf_front sdcf_check #(.ADDR_W(ADDR_W)) u_sdcf_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr_en(bus_wr_en),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_index(req_index),
    .req_arg  (req_arg),
    .rsp_valid(rsp_valid),
    .phase    (state_q.phase),
    .cmd_q    (state_q.cmd),
    .sts_q    (state_q.sts),
    .rsp_q    (state_q.rsp),
    .fail     (rc_fail)
);

// File: tb/test_sdcf_front.sv
`timescale 1ns/1ps
module test_sdcf_front;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr_en = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         req_valid;
    logic         req_ready = 1'b0;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic         rsp_valid = 1'b0;
    logic [4:0]   rsp_len = '0;
    logic [127:0] rsp_payload = '0;
    logic         rsp_err = 1'b0;
    logic         irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sdcf_front i_sdcf_front (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index), .req_arg(req_arg),
        .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_payload(rsp_payload), .rsp_err(rsp_err),
        .irq(irq)
    );

    localparam logic [127:0] LONG_PAY  = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    localparam logic [127:0] SHORT_PAY = 128'hCAFEF00D_11111111_22222222_33333333;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        chk(req, v, exp);
    endtask

    task automatic chk_rsp(input string req, input logic [31:0] w0, w1, w2, w3);
        chk_reg(req, 8'h10, w0);
        chk_reg(req, 8'h14, w1);
        chk_reg(req, 8'h18, w2);
        chk_reg(req, 8'h1C, w3);
    endtask

    // card model: waits for a request, checks it, then replies
    task automatic card_serve(input logic [5:0] idx, input logic [31:0] arg,
                              input logic [4:0] len, input logic [127:0] pay, input logic err);
        int n = 0;
        while (!req_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk("R3 req_valid", 32'(req_valid), 32'd1);
        chk("R3 req_index", 32'(req_index), 32'(idx));
        chk("R3 req_arg", req_arg, arg);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        rsp_valid = 1'b1; rsp_len = len; rsp_payload = pay; rsp_err = err;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
    endtask

    task automatic run_cmd(input logic [15:0] cw, input logic [31:0] arg,
                           input logic [4:0] len, input logic [127:0] pay, input logic err);
        bus_write(8'h04, arg);
        bus_write(8'h00, 32'(cw));
        card_serve(cw[5:0], arg, len, pay, err);
    endtask

    task automatic t_reset();
        chk_reg("R1 cmd", 8'h00, 0);
        chk_reg("R1 arg", 8'h04, 0);
        chk_reg("R1 status", 8'h20, 0);
        chk_reg("R1 config", 8'h38, 0);
        chk_rsp("R1 rsp", 0, 0, 0, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 req_valid", 32'(req_valid), 0);
    endtask

    task automatic t_store();
        bus_write(8'h00, 32'h0000_4A11);
        chk_reg("R2 cmd stored", 8'h00, 32'h0000_4A11);
        repeat (3) begin
            @(negedge clk);
            chk("R2 no request", 32'(req_valid), 0);
        end
        bus_write(8'h04, 32'hA5A5_5A5A);
        chk_reg("R2 arg stored", 8'h04, 32'hA5A5_5A5A);
    endtask

    task automatic t_long();
        run_cmd(16'h8202, 32'h0000_0001, 5'd16, LONG_PAY, 1'b0);
        chk_rsp("R5 long order", 32'hCCDDEEFF, 32'h8899AABB, 32'h44556677, 32'h00112233);
        chk_reg("R3 start cleared", 8'h00, 32'h0000_0202);
        chk_reg("R5 no error", 8'h20, 0);
    endtask

    task automatic t_short();
        run_cmd(16'h8011, 32'h1234_5678, 5'd4, SHORT_PAY, 1'b0);
        chk_rsp("R4 short", 32'hCAFEF00D, 0, 0, 0);
        chk_reg("R4 cmd", 8'h00, 32'h0000_0011);
    endtask

    task automatic err_case(input string req, input logic [15:0] cw, input logic [4:0] len, input logic err);
        run_cmd(cw, 32'h0BAD_0BAD, len, LONG_PAY, err);
        chk_reg({req, " fail flag"}, 8'h00, 32'(cw & 16'h7FFF) | 32'h4000);
        chk_reg({req, " timeout status"}, 8'h20, 32'h40);
        chk_rsp({req, " rsp kept"}, 32'hCAFEF00D, 0, 0, 0);
        bus_write(8'h20, 32'h40);
        chk_reg("R10 clear", 8'h20, 0);
    endtask

    task automatic t_errors();
        err_case("R6 R7 long+4", 16'h8203, 5'd4, 1'b0);
        err_case("R6 R7 len0", 16'h8004, 5'd0, 1'b0);
        err_case("R6 R7 len8", 16'h8005, 5'd8, 1'b0);
        err_case("R6 R7 req err", 16'h8006, 5'd4, 1'b1);
    endtask

    task automatic t_noresp();
        run_cmd(16'h8400, 32'h0, 5'd0, LONG_PAY, 1'b0);
        chk_reg("R8 ok len0", 8'h00, 32'h0000_0400);
        chk_reg("R8 no status", 8'h20, 0);
        chk_rsp("R8 kept len0", 32'hCAFEF00D, 0, 0, 0);
        run_cmd(16'h8407, 32'h0, 5'd16, LONG_PAY, 1'b0);
        chk_rsp("R8 kept len16", 32'hCAFEF00D, 0, 0, 0);
        run_cmd(16'h8408, 32'h0, 5'd0, LONG_PAY, 1'b1);
        chk_reg("R8 req err", 8'h20, 32'h40);
        bus_write(8'h20, 32'hFFFF_FFFF);
    endtask

    task automatic t_busy();
        run_cmd(16'h8809, 32'h0, 5'd4, SHORT_PAY, 1'b0);
        chk_reg("R9 disabled", 8'h20, 0);
        chk("R11 irq low", 32'(irq), 0);
        bus_write(8'h38, 32'h0000_0400);
        chk_reg("R12 config", 8'h38, 32'h0000_0400);
        run_cmd(16'h880A, 32'h0, 5'd4, SHORT_PAY, 1'b1);
        chk_reg("R9 not on error", 8'h20, 32'h40);
        bus_write(8'h20, 32'h40);
        run_cmd(16'h880B, 32'h0, 5'd4, SHORT_PAY, 1'b0);
        chk_reg("R9 enabled", 8'h20, 32'h400);
        chk("R11 irq high", 32'(irq), 1);
        bus_write(8'h20, 32'h40);
        chk_reg("R10 other bit kept", 8'h20, 32'h400);
        chk("R11 irq still high", 32'(irq), 1);
        bus_write(8'h20, 32'h400);
        chk_reg("R10 busy cleared", 8'h20, 0);
        chk("R11 irq low after clear", 32'(irq), 0);
    endtask

    task automatic t_stall();
        bus_write(8'h04, 32'h5555_AAAA);
        bus_write(8'h00, 32'h0000_800C);
        repeat (3) begin
            @(negedge clk);
            chk("R3 held valid", 32'(req_valid), 1);
            chk("R3 held index", 32'(req_index), 32'h0C);
        end
        chk_reg("R3 start pending", 8'h00, 32'h0000_800C);
        bus_write(8'h00, 32'h0000_8005);
        bus_write(8'h04, 32'h0000_0000);
        card_serve(6'h0C, 32'h5555_AAAA, 5'd4, SHORT_PAY, 1'b0);
        chk_reg("R3 ignored write", 8'h00, 32'h0000_000C);
        chk_reg("R3 arg kept", 8'h04, 32'h5555_AAAA);
    endtask

    task automatic t_unknown();
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'hFFFF_FFFF);
        chk_reg("R12 unknown 0x24", 8'h24, 0);
        chk_reg("R12 unknown 0x08", 8'h08, 0);
        chk_reg("R12 status untouched", 8'h20, 0);
        chk_reg("R12 arg untouched", 8'h04, 32'h5555_AAAA);
        chk_rsp("R12 rsp untouched", 32'hCAFEF00D, 0, 0, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store();
        t_long();
        t_short();
        t_errors();
        t_noresp();
        t_busy();
        t_stall();
        t_unknown();
        summary();
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R1..: act=timeout exp=done");
        summary();
    end
endmodule